// File: doc/BRIEF.md
# Flyby DMA Transfer Channel

This block is a single DMA channel that moves data between an external memory and an external device without holding the data itself. For each transfer it runs one bus cycle. It drives the memory address and a read or write strobe on the memory side. In the same cycle it selects the device with an active-low acknowledge, so the data crosses the shared bus directly from one side to the other. The access size always equals the data bus width, so the channel never packs or splits data.

Software sets up the channel through a small register write port. It loads a source address, a destination address, a transfer count and a control word, then sets the enable bit. While the channel is enabled and the count is nonzero, it waits for the device request. It then requests the bus, waits for a grant, can optionally insert one idle cycle, and performs the transfer. After each transfer it decrements the count and can step the memory address. When the count reaches zero the channel clears its enable, which is also its busy flag.

Top module: `flyby_dma_chan`

## Requirements
- R1: After reset, bus_req_o, mem_rd_o, mem_wr_o, eot_o and busy_o are 0, dev_ack_no is 1 and addr_o is 0.
- R2: The channel raises bus_req_o only while enabled (control bit 0), with a nonzero count and dreq_i high. It holds the request until the transfer cycle is done and starts no bus cycle before bus_gnt_i is seen high.
- R3: Each transfer takes exactly one bus cycle, with one strobe asserted for a single clock. Without an idle gap, that cycle follows the clock in which the grant is seen.
- R4: With direction bit 0 (control bit 1) the bus cycle drives the source address on addr_o with mem_rd_o high and mem_wr_o low. Outside bus cycles addr_o is 0 and both strobes are low.
- R5: With direction bit 1 the bus cycle drives the destination address with mem_wr_o high and mem_rd_o low.
- R6: dev_ack_no goes low only during bus cycles, and only when the acknowledge enable (control bit 2) is set. Otherwise it stays high.
- R7: When the end enable (control bit 3) is set, eot_o is high during the bus cycle of the transfer that takes the count from 1 to 0, and at no other bus cycle.
- R8: When idle insertion (control bit 5) is set, exactly one cycle with bus_req_o high and no strobe separates the grant from the bus cycle. If that transfer is the final one and the end enable is set, eot_o is also high in that idle cycle.
- R9: With address step (control bit 4) set, the address register in use advances by BUS_BYTES after every transfer. With it clear, the address stays fixed.
- R10: The address register not selected by the direction bit is never updated by transfers.
- R11: The count decrements by one per transfer. When it reaches zero, busy_o (the enable bit) clears and no further transfer starts even with dreq_i held high. Enabling with a count of zero starts no transfer.
- R12: Writes to the source (select 0), destination (select 1) and count (select 2) registers are ignored while the channel is enabled. Control writes (select 3) always take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| reg_wdata_i | input | AW | Register write data |
| dreq_i | input | 1 | Device transfer request |
| bus_gnt_i | input | 1 | Bus grant |
| bus_req_o | output | 1 | Bus request, held through the transfer |
| addr_o | output | AW | Memory address during the bus cycle |
| mem_rd_o | output | 1 | Memory read strobe (memory to device) |
| mem_wr_o | output | 1 | Memory write strobe (device to memory) |
| dev_ack_no | output | 1 | Device acknowledge, active low |
| eot_o | output | 1 | End-of-transfer marker |
| busy_o | output | 1 | Channel enabled and not yet terminated |

## Verification
The channel is run in both directions, with address stepping on and off, with grants that are immediate or delayed by several cycles, and with and without the idle gap. These runs separate the address source, the strobe choice and the end-marker timing. Back-to-back runs in alternating directions show whether the unused address register moved. Further runs cover holding the device request low, enabling with a zero count, and writing the count and address while a transfer is pending on the grant. These show whether the start conditions and the write blocking are honoured. A behavioural model is compared against every output on every clock, and scenario totals (bus cycles, end markers, final addresses) are checked after each run.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_GAP  = 2'd2,
    ST_BUS  = 2'd3
  } seq_state_e;

  localparam int unsigned SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_SRC = 2'd0;
  localparam logic [SEL_W-1:0] SEL_DST = 2'd1;
  localparam logic [SEL_W-1:0] SEL_CNT = 2'd2;
  localparam logic [SEL_W-1:0] SEL_CTL = 2'd3;

  // bit 0 is enable, bit 5 is idle gap
  typedef struct packed {
    logic idle_gap;
    logic addr_inc;
    logic eot_en;
    logic ack_en;
    logic dir;
    logic enable;
  } chan_ctl_t;

  localparam int unsigned CTL_W = $bits(chan_ctl_t);

endpackage

// File: rtl/flyby_dma_regs.sv
module flyby_dma_regs
  import flyby_dma_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned CW        = 16,
  parameter int unsigned BUS_BYTES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [AW-1:0]    wdata_i,
  input  logic             xfer_done_i,
  output logic [AW-1:0]    src_o,
  output logic [AW-1:0]    dst_o,
  output chan_ctl_t        ctl_o,
  output logic             cnt_nz_o,
  output logic             last_o
);

  localparam logic [AW-1:0] STEP = AW'(BUS_BYTES);

  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  chan_ctl_t     ctl_q;
  logic          setup_open;

  assign setup_open = !ctl_q.enable;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      ctl_q <= '0;
    end else begin
      if (we_i) begin
        unique case (sel_i)
          SEL_SRC: if (setup_open) src_q <= wdata_i;
          SEL_DST: if (setup_open) dst_q <= wdata_i;
          SEL_CNT: if (setup_open) cnt_q <= wdata_i[CW-1:0];
          default: ctl_q <= chan_ctl_t'(wdata_i[CTL_W-1:0]);
        endcase
      end
      // transfer bookkeeping overrides a same-cycle write
      if (xfer_done_i) begin
        if (ctl_q.addr_inc) begin
          if (ctl_q.dir) dst_q <= dst_q + STEP;
          else           src_q <= src_q + STEP;
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) ctl_q.enable <= 1'b0;
      end
    end
  end

  assign src_o    = src_q;
  assign dst_o    = dst_q;
  assign ctl_o    = ctl_q;
  assign cnt_nz_o = (cnt_q != '0);
  assign last_o   = (cnt_q == CW'(1));

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(we_i && sel_i == SEL_CNT) && cnt_q != $past(cnt_q))
      |-> cnt_q == CW'($past(cnt_q) - 1'b1)); // R11

  AST_UNUSED_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_done_i && ctl_q.dir && !(we_i && sel_i == SEL_SRC)) |=> $stable(src_q)); // R10

  AST_UNUSED_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_done_i && !ctl_q.dir && !(we_i && sel_i == SEL_DST)) |=> $stable(dst_q)); // R10

  AST_FIXED_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_done_i && !ctl_q.addr_inc && !we_i) |=> ($stable(src_q) && $stable(dst_q))); // R9

endmodule

// File: rtl/flyby_dma_seq.sv
module flyby_dma_seq
  import flyby_dma_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          dir_i,
  input  logic          ack_en_i,
  input  logic          eot_en_i,
  input  logic          idle_gap_i,
  input  logic          cnt_nz_i,
  input  logic          last_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic          dreq_i,
  input  logic          bus_gnt_i,
  output logic          bus_req_o,
  output logic [AW-1:0] addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          dev_ack_no,
  output logic          eot_o,
  output logic          xfer_done_o
);

  seq_state_e state_q, state_d;
  logic       in_bus, in_gap;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (enable_i && cnt_nz_i && dreq_i) state_d = ST_REQ;
      ST_REQ:  if (bus_gnt_i) state_d = idle_gap_i ? ST_GAP : ST_BUS;
      ST_GAP:  state_d = ST_BUS;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign in_bus      = (state_q == ST_BUS);
  assign in_gap      = (state_q == ST_GAP);
  assign bus_req_o   = (state_q != ST_IDLE);
  assign mem_rd_o    = in_bus && !dir_i;
  assign mem_wr_o    = in_bus && dir_i;
  assign addr_o      = in_bus ? (dir_i ? dst_i : src_i) : '0;
  assign dev_ack_no  = !(in_bus && ack_en_i);
  assign eot_o       = eot_en_i && last_i && (in_bus || in_gap);
  assign xfer_done_o = in_bus;

  AST_ONE_BUS_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |=> !(mem_rd_o || mem_wr_o)); // R3

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R4

  AST_STROBE_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |-> bus_req_o); // R2

  AST_ACK_IN_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dev_ack_no |-> (mem_rd_o || mem_wr_o)); // R6

  AST_GAP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_gap |-> (bus_req_o && !mem_rd_o && !mem_wr_o && dev_ack_no)); // R8

endmodule

// File: rtl/flyby_dma_chan.sv
module flyby_dma_chan
  import flyby_dma_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned CW        = 16,
  parameter int unsigned BUS_BYTES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [AW-1:0] reg_wdata_i,
  input  logic          dreq_i,
  input  logic          bus_gnt_i,
  output logic          bus_req_o,
  output logic [AW-1:0] addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          dev_ack_no,
  output logic          eot_o,
  output logic          busy_o
);

  logic [AW-1:0] src, dst;
  chan_ctl_t     ctl;
  logic          cnt_nz, last, xfer_done;

  flyby_dma_regs #(
    .AW(AW), .CW(CW), .BUS_BYTES(BUS_BYTES)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .sel_i      (reg_sel_i),
    .wdata_i    (reg_wdata_i),
    .xfer_done_i(xfer_done),
    .src_o      (src),
    .dst_o      (dst),
    .ctl_o      (ctl),
    .cnt_nz_o   (cnt_nz),
    .last_o     (last)
  );

  flyby_dma_seq #(
    .AW(AW)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (ctl.enable),
    .dir_i      (ctl.dir),
    .ack_en_i   (ctl.ack_en),
    .eot_en_i   (ctl.eot_en),
    .idle_gap_i (ctl.idle_gap),
    .cnt_nz_i   (cnt_nz),
    .last_i     (last),
    .src_i      (src),
    .dst_i      (dst),
    .dreq_i     (dreq_i),
    .bus_gnt_i  (bus_gnt_i),
    .bus_req_o  (bus_req_o),
    .addr_o     (addr_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .dev_ack_no (dev_ack_no),
    .eot_o      (eot_o),
    .xfer_done_o(xfer_done)
  );

  assign busy_o = ctl.enable;

  AST_EOT_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eot_o |-> (last && bus_req_o)); // R7

  AST_TERMINAL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_done && last && !reg_we_i) |=> !busy_o); // R11

endmodule

// File: tb/flyby_dma_chan_tb.sv
module flyby_dma_chan_tb;

  localparam int unsigned AW = 32;
  localparam int unsigned CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [1:0]    sel = '0;
  logic [AW-1:0] wdata = '0;
  logic          dreq = 1'b0;
  logic          gnt = 1'b0;
  logic          bus_req, rd, wr, ack_n, eot, busy;
  logic [AW-1:0] addr;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk; // 50 MHz

  flyby_dma_chan #(.AW(AW), .CW(CW), .BUS_BYTES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .dreq_i(dreq), .bus_gnt_i(gnt),
    .bus_req_o(bus_req), .addr_o(addr), .mem_rd_o(rd), .mem_wr_o(wr),
    .dev_ack_no(ack_n), .eot_o(eot), .busy_o(busy)
  );

  task automatic chk(input string req, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [AW-1:0] m_src, m_dst;
  logic [CW-1:0] m_cnt;
  bit m_en, m_dir, m_ack, m_eot, m_inc, m_gap;
  int m_ph; // 0 idle, 1 waiting grant, 2 idle gap, 3 transfer

  always @(posedge clk or negedge rst_n) begin
    int nph;
    bit o_dir, o_inc, o_en;
    logic [CW-1:0] o_cnt;
    if (!rst_n) begin
      m_src = '0; m_dst = '0; m_cnt = '0;
      {m_en, m_dir, m_ack, m_eot, m_inc, m_gap} = '0;
      m_ph = 0;
    end else begin
      nph = m_ph;
      case (m_ph)
        0: if (m_en && m_cnt != 0 && dreq) nph = 1;
        1: if (gnt) nph = m_gap ? 2 : 3;
        2: nph = 3;
        default: nph = 0;
      endcase
      o_dir = m_dir; o_inc = m_inc; o_cnt = m_cnt; o_en = m_en;
      if (we) begin
        case (sel)
          2'd0: if (!o_en) m_src = wdata;
          2'd1: if (!o_en) m_dst = wdata;
          2'd2: if (!o_en) m_cnt = wdata[CW-1:0];
          default: begin
            m_en = wdata[0]; m_dir = wdata[1]; m_ack = wdata[2];
            m_eot = wdata[3]; m_inc = wdata[4]; m_gap = wdata[5];
          end
        endcase
      end
      if (m_ph == 3) begin
        if (o_inc) begin
          if (o_dir) m_dst = m_dst + 2;
          else       m_src = m_src + 2;
        end
        m_cnt = o_cnt - 1'b1;
        if (o_cnt == 1) m_en = 0;
      end
      m_ph = nph;
    end
  end

  // per-cycle comparison and scenario monitors
  int n_bus = 0, n_eot = 0, n_eot_idle = 0, n_ack = 0;
  logic [AW-1:0] last_addr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit inb;
      inb = (m_ph == 3);
      chk("R2", "bus_req", AW'(bus_req), AW'(m_ph != 0));
      chk(m_dir ? "R5" : "R4", "addr", addr, inb ? (m_dir ? m_dst : m_src) : '0);
      chk("R4", "mem_rd", AW'(rd), AW'(inb && !m_dir));
      chk("R5", "mem_wr", AW'(wr), AW'(inb && m_dir));
      chk("R6", "dev_ack_n", AW'(ack_n), AW'(!(inb && m_ack)));
      chk(m_ph == 2 ? "R8" : "R7", "eot", AW'(eot),
          AW'(m_eot && m_cnt == 1 && (m_ph == 2 || m_ph == 3)));
      chk("R11", "busy", AW'(busy), AW'(m_en));
      if (rd || wr) begin n_bus++; last_addr = addr; end
      if (eot) n_eot++;
      if (eot && !(rd || wr)) n_eot_idle++;
      if (!ack_n) n_ack++;
    end
  end

  // grant driver with programmable latency
  int gnt_dly = 0, gwait = 0;
  always @(negedge clk) begin
    #1;
    if (bus_req) begin
      if (gwait >= gnt_dly) gnt = 1'b1;
      else gwait++;
    end else begin
      gnt = 1'b0; gwait = 0;
    end
  end

  task automatic wreg(input logic [1:0] s, input logic [AW-1:0] d);
    @(negedge clk); #1;
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk); #1;
    we = 1'b0;
  endtask

  task automatic clr_mon();
    n_bus = 0; n_eot = 0; n_eot_idle = 0; n_ack = 0;
  endtask

  task automatic wait_done(input string req);
    int t;
    t = 0;
    do begin
      @(negedge clk); #2;
      t++;
    end while ((busy || bus_req) && t < 500);
    if (t >= 500) chk(req, "run timeout", 1, 0);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R3 watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "bus_req", AW'(bus_req), 0);
    chk("R1", "strobes", AW'({rd, wr}), 0);
    chk("R1", "ack_n", AW'(ack_n), 1);
    chk("R1", "eot", AW'(eot), 0);
    chk("R1", "busy", AW'(busy), 0);
    chk("R1", "addr", addr, 0);
    #1 rst_n = 1'b1;

    // memory to device, stepping, immediate grant
    wreg(2'd0, 32'h1000); wreg(2'd1, 32'h2000); wreg(2'd2, 3);
    clr_mon(); dreq = 1'b1;
    wreg(2'd3, 32'h1D);
    wait_done("R11");
    chk("R3", "bus cycles dir0", n_bus, 3);
    chk("R7", "eot count", n_eot, 1);
    chk("R9", "last stepped src", last_addr, 32'h1004);
    repeat (10) @(negedge clk);
    chk("R11", "no transfer after terminal", n_bus, 3);

    // device to memory, delayed grant, idle gap
    gnt_dly = 3; clr_mon();
    wreg(2'd2, 2); wreg(2'd3, 32'h3F);
    wait_done("R8");
    chk("R5", "bus cycles dir1", n_bus, 2);
    chk("R5", "last dst", last_addr, 32'h2002);
    chk("R8", "eot incl idle", n_eot, 2);
    chk("R8", "eot in idle cycle", n_eot_idle, 1);

    // source untouched by dir1 run, ack and eot disabled
    gnt_dly = 0; clr_mon();
    wreg(2'd2, 1); wreg(2'd3, 32'h11);
    wait_done("R10");
    chk("R10", "src after dir1 run", last_addr, 32'h1006);
    chk("R6", "ack stayed high", n_ack, 0);
    chk("R7", "eot disabled", n_eot, 0);

    // fixed address
    clr_mon();
    wreg(2'd2, 3); wreg(2'd3, 32'h05);
    wait_done("R9");
    chk("R9", "fixed addr", last_addr, 32'h1008);
    chk("R6", "ack cycles", n_ack, 3);
    clr_mon();
    wreg(2'd2, 1); wreg(2'd3, 32'h11);
    wait_done("R9");
    chk("R9", "src not stepped by fixed run", last_addr, 32'h1008);

    // no request: no bus activity
    dreq = 1'b0; clr_mon();
    wreg(2'd2, 2); wreg(2'd3, 32'h05);
    repeat (10) @(negedge clk);
    chk("R2", "no transfer without dreq", n_bus, 0);
    chk("R2", "no bus_req without dreq", AW'(bus_req), 0);

    // writes while enabled are ignored; hold grant off meanwhile
    gnt_dly = 50; dreq = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2", "no bus cycle before grant", n_bus, 0);
    wreg(2'd2, 7); wreg(2'd0, 32'h5000);
    gnt_dly = 0;
    wait_done("R12");
    chk("R12", "count write ignored", n_bus, 2);
    chk("R12", "src write ignored", last_addr, 32'h100A);

    // zero count: enable but nothing moves
    clr_mon();
    wreg(2'd2, 0); wreg(2'd3, 32'h01);
    repeat (10) @(negedge clk);
    chk("R11", "zero count no transfer", n_bus, 0);
    wreg(2'd3, 0);
    repeat (2) @(negedge clk);

    summary();
    $finish;
  end

endmodule